// File: doc/BRIEF.md
# Split-Operand 32x32 Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product a fixed number of cycles later. No full-width multiplier is used. Each operand is cut into a 16-bit upper half and a 16-bit lower half. Four narrow multipliers each form one 32-bit partial product from one half of each operand. The partial products are registered, the two mixed-half terms are summed, and a final 64-bit addition places every term at its weight. Those three register stages set the latency.

The caller pulses `start` with both operands. The operands are captured only when the unit is idle. Exactly one cycle later than the second register stage, `done` pulses for a single cycle and `result` carries the product. `result` then stays unchanged until the next accepted operation completes. The narrow multipliers are built either from the synthesis multiply operator or from an unrolled shift-and-add array, selected by a parameter.

Top module: `split_mult32`

## Requirements
- R1: When `done` is high, `result` equals the unsigned product of the `op_a` and `op_b` values that were captured with the accepted `start`.
- R2: When `start` is sampled high at a rising edge with the unit idle, `done` is low after the first and second following edges. It is high for exactly one cycle after the third edge counted from the accepting edge, that edge included.
- R3: A `start` sampled while an accepted operation is still in its first or second stage is ignored. It produces no extra `done` pulse, and its operands never reach `result`.
- R4: A `start` sampled in the same cycle that `done` is high is accepted. Its product appears with `done` three edges later, so a new operation can be issued every three cycles.
- R5: Between `done` pulses, `result` holds its value, however long the unit stays idle.
- R6: A synchronous reset (`rst` high at a rising edge) clears `done` and `result` to zero and discards any operation in flight, so no `done` follows it.
- R7: Carries out of the summed mixed-half terms reach the upper word. Operands 0xFFFFFFFF × 0xFFFFFFFF give 0xFFFFFFFE00000001, and 0xFFFF0000 × 0x0000FFFF gives 0x0000FFFE00010000.
- R8: Zero in either operand gives a zero product, and operand 1 returns the other operand unchanged in the low word with a zero upper word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to multiply the present operands |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| result | output | 64 | Registered 64-bit product |
| done | output | 1 | One-cycle pulse marking a new product |

## Verification
Operands are chosen so that each partial product is tested on its own, then in combinations. Values confined to one half of each operand light up only one of the four narrow products, which shows a misplaced or swapped term. All-ones and half-ones operands force carries out of the mixed-term sum and the final adder, which shows a truncated carry. Zero and one operands expose stray bits. Timing patterns issue `start` while the pipeline is busy, in the `done` cycle, and just before a reset. These separate correct acceptance from a design that restarts or drops work.

// File: rtl/mulpp_pkg.sv
package mulpp_pkg;

   // Implementation of each narrow partial-product multiplier
   typedef enum logic [0:0] {
      MUL_OPERATOR  = 1'b0,
      MUL_SHIFT_ADD = 1'b1
   } mul_impl_e;

   // Partial product index: bit 1 picks the half of A, bit 0 the half of B
   localparam int unsigned PP_COUNT = 4;
   localparam int unsigned PP_LL    = 0;
   localparam int unsigned PP_LH    = 1;
   localparam int unsigned PP_HL    = 2;
   localparam int unsigned PP_HH    = 3;

endpackage

// File: rtl/mulpp_half_mul.sv
module mulpp_half_mul
   import mulpp_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter mul_impl_e   IMPL = MUL_OPERATOR
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);

   localparam int unsigned PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("mulpp_half_mul: W must be at least 2");
      end

      if (IMPL == MUL_OPERATOR) begin : g_operator
         assign p = PW'(a) * PW'(b);
      end else begin : g_shift_add
         always_comb begin
            p = '0;
            for (int i = 0; i < int'(W); i++) begin
               if (b[i]) p = p + (PW'(a) << i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mulpp_ctrl.sv
module mulpp_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic accept,
   output logic s2_en,
   output logic s3_en,
   output logic done
);

   logic v1_q, v2_q, done_q;

   // Idle whenever neither of the first two stages holds work
   assign accept = start && !v1_q && !v2_q;
   assign s2_en  = v1_q;
   assign s3_en  = v2_q;
   assign done   = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1_q   <= 1'b0;
         v2_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         v1_q   <= accept;
         v2_q   <= v1_q;
         done_q <= v2_q;
      end
   end

   // R2: stage two always leads to done on the next edge
   p_done_after_s2_r2: assert property (@(posedge clk) disable iff (rst)
      v2_q |=> done_q);

   // R2: done is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);

   // R3: a start seen during stage one starts nothing new
   p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
      v1_q |=> (v2_q && !v1_q));

   // R4: a start in the done cycle is taken
   p_accept_on_done_r4: assert property (@(posedge clk) disable iff (rst)
      (done_q && start) |=> v1_q);

endmodule

// File: rtl/mulpp_combine.sv
module mulpp_combine #(
   parameter int unsigned H = 16
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           s2_en,
   input  logic           s3_en,
   input  logic [2*H-1:0] pp_ll,
   input  logic [2*H-1:0] pp_lh,
   input  logic [2*H-1:0] pp_hl,
   input  logic [2*H-1:0] pp_hh,
   output logic [4*H-1:0] result
);

   localparam int unsigned PPW = 2 * H;
   localparam int unsigned XW  = PPW + 1;
   localparam int unsigned RW  = 4 * H;

   logic [XW-1:0] cross_q;
   logic [RW-1:0] outer_q;
   logic [RW-1:0] result_q;

   // Stage 2: add the mixed-half terms; concatenate the aligned outer terms
   always_ff @(posedge clk) begin
      if (s2_en) begin
         cross_q <= XW'(pp_lh) + XW'(pp_hl);
         outer_q <= {pp_hh, pp_ll};
      end
   end

   // Stage 3: fold the mixed sum in at weight 2^H
   always_ff @(posedge clk) begin
      if (rst) begin
         result_q <= '0;
      end else if (s3_en) begin
         result_q <= outer_q + (RW'(cross_q) << H);
      end
   end

   assign result = result_q;

   // R5: the product register only moves on a completion step
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !s3_en |=> $stable(result_q));

endmodule

// File: rtl/split_mult32.sv
module split_mult32
   import mulpp_pkg::*;
#(
   parameter int unsigned OP_W = 32,
   parameter mul_impl_e   IMPL = MUL_OPERATOR
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [2*OP_W-1:0] result,
   output logic              done
);

   localparam int unsigned H   = OP_W / 2;
   localparam int unsigned PPW = 2 * H;
   localparam int unsigned RW  = 2 * OP_W;

   generate
      if ((OP_W % 2) != 0 || OP_W < 4) begin : g_bad_opw
         $error("split_mult32: OP_W must be even and at least 4");
      end
   endgenerate

   logic accept, s2_en, s3_en;

   mulpp_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .accept (accept),
      .s2_en  (s2_en),
      .s3_en  (s3_en),
      .done   (done)
   );

   logic [H-1:0]   a_half [2];
   logic [H-1:0]   b_half [2];
   logic [PPW-1:0] pp_d   [PP_COUNT];
   logic [PPW-1:0] pp_q   [PP_COUNT];

   assign a_half[0] = op_a[H-1:0];
   assign a_half[1] = op_a[OP_W-1:H];
   assign b_half[0] = op_b[H-1:0];
   assign b_half[1] = op_b[OP_W-1:H];

   // Stage 1: four narrow multipliers, one register each
   for (genvar g = 0; g < PP_COUNT; g++) begin : g_pp
      localparam int unsigned AI = (g >> 1) & 1;
      localparam int unsigned BI = g & 1;

      mulpp_half_mul #(.W(H), .IMPL(IMPL)) u_mul (
         .a (a_half[AI]),
         .b (b_half[BI]),
         .p (pp_d[g])
      );

      always_ff @(posedge clk) begin
         if (accept) pp_q[g] <= pp_d[g];
      end
   end

   mulpp_combine #(.H(H)) u_combine (
      .clk    (clk),
      .rst    (rst),
      .s2_en  (s2_en),
      .s3_en  (s3_en),
      .pp_ll  (pp_q[PP_LL]),
      .pp_lh  (pp_q[PP_LH]),
      .pp_hl  (pp_q[PP_HL]),
      .pp_hh  (pp_q[PP_HH]),
      .result (result)
   );

   // R1: the completed product matches the operands taken three edges back
   p_product_r1: assert property (@(posedge clk) disable iff (rst)
      done |-> (result == (RW'($past(op_a, 3)) * RW'($past(op_b, 3)))));

   // R6: reset leaves nothing in flight to complete
   p_reset_clear_r6: assert property (@(posedge clk)
      rst |=> (!done && result == '0));

endmodule

// File: tb/split_mult32_tb.sv
module split_mult32_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [63:0] result;
   logic        done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   split_mult32 u_dut (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .op_a   (op_a),
      .op_b   (op_b),
      .result (result),
      .done   (done)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] prod(input logic [31:0] a, input logic [31:0] b);
      return {32'h0, a} * {32'h0, b};
   endfunction

   // R2 latency and R1 value for one isolated operation
   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string tag);
      logic [63:0] exp = prod(a, b);
      start = 1'b1; op_a = a; op_b = b;
      tick();
      start = 1'b0;
      check(done == 1'b0, "R2 done low after edge 1", 64'(done), 64'd0);
      tick();
      check(done == 1'b0, "R2 done low after edge 2", 64'(done), 64'd0);
      tick();
      check(done == 1'b1, "R2 done high after edge 3", 64'(done), 64'd1);
      check(result == exp, tag, result, exp);
      tick();
      check(done == 1'b0, "R2 done single cycle", 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      tick(); tick();
      check(done == 1'b0, "R6 done after reset", 64'(done), 64'd0);
      check(result == 64'd0, "R6 result after reset", result, 64'd0);
      rst = 1'b0;
      tick();
   endtask

   task automatic t_patterns();
      run_op(32'h0000_0003, 32'h0000_0005, "R1 low x low");
      run_op(32'h0007_0000, 32'h0000_0009, "R1 high x low");
      run_op(32'h0000_000B, 32'h000D_0000, "R1 low x high");
      run_op(32'h0011_0000, 32'h0013_0000, "R1 high x high");
      run_op(32'h1234_5678, 32'h9ABC_DEF0, "R1 mixed");
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 all ones");
      run_op(32'hFFFF_0000, 32'h0000_FFFF, "R7 half ones");
      run_op(32'hDEAD_BEEF, 32'h0000_0000, "R8 zero operand");
      run_op(32'h0000_0001, 32'hCAFE_F00D, "R8 unit operand");
   endtask

   task automatic t_busy();
      logic [63:0] exp = prod(32'h0001_0003, 32'h0002_0005);
      start = 1'b1; op_a = 32'h0001_0003; op_b = 32'h0002_0005;
      tick();
      op_a = 32'h0F0F_0F0F; op_b = 32'h7777_7777;   // still high: stage one busy
      tick();
      op_a = 32'h5555_5555; op_b = 32'h3333_3333;   // still high: stage two busy
      check(done == 1'b0, "R3 no early done", 64'(done), 64'd0);
      tick();
      start = 1'b0;
      check(done == 1'b1, "R3 first op completes", 64'(done), 64'd1);
      check(result == exp, "R3 busy operands ignored", result, exp);
      for (int i = 0; i < 4; i++) begin
         tick();
         check(done == 1'b0, "R3 no extra done", 64'(done), 64'd0);
      end
      check(result == exp, "R3 result unchanged", result, exp);
   endtask

   task automatic t_done_cycle();
      logic [63:0] exp = prod(32'h8000_0001, 32'h0000_FFFF);
      start = 1'b1; op_a = 32'h0000_0101; op_b = 32'h0000_0202;
      tick();
      start = 1'b0;
      tick(); tick();
      check(done == 1'b1, "R4 first done", 64'(done), 64'd1);
      start = 1'b1; op_a = 32'h8000_0001; op_b = 32'h0000_FFFF;
      tick();
      start = 1'b0;
      check(done == 1'b0, "R4 done low after reissue", 64'(done), 64'd0);
      tick(); tick();
      check(done == 1'b1, "R4 second done", 64'(done), 64'd1);
      check(result == exp, "R4 second product", result, exp);
      tick();
   endtask

   task automatic t_hold();
      logic [63:0] exp = prod(32'h0BAD_CAFE, 32'h0000_1234);
      run_op(32'h0BAD_CAFE, 32'h0000_1234, "R5 setup product");
      op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
      for (int i = 0; i < 10; i++) tick();
      check(result == exp, "R5 result held while idle", result, exp);
      check(done == 1'b0, "R5 no done while idle", 64'(done), 64'd0);
   endtask

   task automatic t_reset_in_flight();
      start = 1'b1; op_a = 32'h1111_1111; op_b = 32'h2222_2222;
      tick();
      start = 1'b0;
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check(result == 64'd0, "R6 result cleared mid-op", result, 64'd0);
      for (int i = 0; i < 5; i++) begin
         tick();
         check(done == 1'b0, "R6 flight discarded", 64'(done), 64'd0);
      end
      check(result == 64'd0, "R6 result stays zero", result, 64'd0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_patterns();
      t_busy();
      t_done_cycle();
      t_hold();
      t_reset_in_flight();
      run_op(32'hFFFF_FFFF, 32'h0001_0001, "R1 after reset recovery");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule